// File: doc/BRIEF.md
# Sensor Startup Sequencer and Reset-Interval Watchdog

This block decides when a current-sense front end may trust its integrator. It reads two digitized supply comparisons (above the lower threshold, and above the lower threshold plus hysteresis), a done flag from the calibration engine and the integrator reset request coming from the reset decoder. From these it walks through four operating states: lockout, self-calibration, waiting for the first integrator reset, and steady reset/measure operation.

Until steady operation is reached, the block pins the measurement outputs to their minimum value and masks the reset request path. It launches the self-calibration with a single-cycle start pulse. In steady operation a watchdog times each measurement interval, meaning the clocks during which no reset is requested. When an interval runs on for too long, the block drives an active-low fault flag and forces the outputs to minimum. The fault clears as soon as the next reset cycle begins. A supply drop sends the block back to lockout from any state.

Top module: `sense_supervisor`

## Requirements
- R1: After a synchronous reset the outputs read out_force_min=1, reset_enable=0, cal_start=0 and fault_n=1.
- R2: When sup_above_lo is sampled low in any state, the next cycle shows out_force_min=1, reset_enable=0 and fault_n=1, and the block is in lockout.
- R3: Lockout is left only when sup_above_hi is sampled high; sup_above_lo alone keeps the block in lockout. Outside lockout, sup_above_hi low with sup_above_lo high does not return the block to lockout.
- R4: cal_start is high for exactly one cycle, in the cycle after the edge on which the block leaves lockout.
- R5: During self-calibration out_force_min=1 and reset_enable=0, and reset_req has no effect.
- R6: A high cal_done during calibration moves the block to the waiting state (reset_enable=1, out_force_min=1). The block stays there until reset_req is seen.
- R7: The first reset_req sampled in the waiting state starts steady operation, and out_force_min=0 from the next cycle.
- R8: In steady operation, WD_TIMEOUT consecutive clocks with reset_req low drive fault_n low. WD_TIMEOUT-1 such clocks do not.
- R9: While the fault is active, fault_n=0 and out_force_min=1, and the fault persists for as long as reset_req stays low.
- R10: A reset_req sampled high while faulted clears the fault: fault_n=1 and out_force_min=0 on the next cycle.
- R11: The interval timer is cleared and held while reset_req is high, so a long reset never causes a fault and the next interval gets a full WD_TIMEOUT clocks.
- R12: cal_done has no effect outside calibration; every exit from lockout goes through calibration again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sup_above_lo | input | 1 | Supply above the lower lockout threshold |
| sup_above_hi | input | 1 | Supply above the lower threshold plus hysteresis |
| cal_done | input | 1 | Self-calibration finished |
| reset_req | input | 1 | Integrator reset requested by the reset decoder |
| out_force_min | output | 1 | Hold measurement outputs at minimum |
| reset_enable | output | 1 | Reset request path unmasked |
| cal_start | output | 1 | One-cycle calibration launch pulse |
| fault_n | output | 1 | Active-low measurement watchdog fault |

## Verification
The supply inputs are stepped with the lower comparison alone, with both comparisons, and with only the upper one dropping. This separates a true hysteresis band from a single threshold, and a second calibration start pulse shows whether lockout was really re-entered. Reset requests are applied during calibration, as the first request after it, as short pulses, and as holds far longer than the timeout. Measurement intervals of exactly WD_TIMEOUT-1 and WD_TIMEOUT clocks pin the trip point to the cycle. Supply drops are applied from calibration and from a faulted run, to confirm that lockout overrides every other state.

// File: rtl/supervisor_pkg.sv
package supervisor_pkg;

  typedef enum logic [1:0] {
    ST_LOCK = 2'd0,
    ST_CAL  = 2'd1,
    ST_WAIT = 2'd2,
    ST_RUN  = 2'd3
  } sup_state_e;

endpackage

// File: rtl/supply_seq_fsm.sv
module supply_seq_fsm
  import supervisor_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       sup_lo,
  input  logic       sup_hi,
  input  logic       cal_done,
  input  logic       reset_req,
  output sup_state_e state_q,
  output sup_state_e state_d
);

  always_comb begin
    state_d = state_q;
    if (!sup_lo) begin
      state_d = ST_LOCK;
    end else begin
      unique case (state_q)
        ST_LOCK: if (sup_hi)    state_d = ST_CAL;
        ST_CAL:  if (cal_done)  state_d = ST_WAIT;
        ST_WAIT: if (reset_req) state_d = ST_RUN;
        ST_RUN:                 state_d = ST_RUN;
        default:                state_d = ST_LOCK;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_LOCK;
    else     state_q <= state_d;
  end

  // R3
  lock_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_LOCK && !sup_hi) |=> state_q == ST_LOCK);

  // R5
  cal_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_CAL && sup_lo && !cal_done) |=> state_q == ST_CAL);

  // R7
  first_reset_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WAIT && sup_lo && reset_req) |=> state_q == ST_RUN);

endmodule

// File: rtl/reset_interval_wd.sv
module reset_interval_wd #(
  parameter int WD_TIMEOUT = 12500
) (
  input  logic clk,
  input  logic rst,
  input  logic run_next,
  input  logic reset_req,
  output logic trip_next
);

  localparam int CW = $clog2(WD_TIMEOUT + 1);
  localparam logic [CW-1:0] LIMIT = CW'(WD_TIMEOUT);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (!run_next || reset_req)  cnt_d = '0;
    else if (cnt_q != LIMIT)     cnt_d = cnt_q + 1'b1;
    else                         cnt_d = cnt_q;
  end

  assign trip_next = run_next && !reset_req && (cnt_d == LIMIT);

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end

  // R11
  clear_on_reset_chk: assert property (@(posedge clk) disable iff (rst)
    reset_req |=> cnt_q == '0);

  // R9
  saturate_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == LIMIT && run_next && !reset_req) |=> cnt_q == LIMIT);

endmodule

// File: rtl/sense_supervisor.sv
module sense_supervisor
  import supervisor_pkg::*;
#(
  parameter int WD_TIMEOUT = 12500
) (
  input  logic clk,
  input  logic rst,
  input  logic sup_above_lo,
  input  logic sup_above_hi,
  input  logic cal_done,
  input  logic reset_req,
  output logic out_force_min,
  output logic reset_enable,
  output logic cal_start,
  output logic fault_n
);

  sup_state_e state_q, state_d;
  logic       trip_next;

  supply_seq_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .sup_lo    (sup_above_lo),
    .sup_hi    (sup_above_hi),
    .cal_done  (cal_done),
    .reset_req (reset_req),
    .state_q   (state_q),
    .state_d   (state_d)
  );

  reset_interval_wd #(.WD_TIMEOUT(WD_TIMEOUT)) u_wd (
    .clk       (clk),
    .rst       (rst),
    .run_next  (state_d == ST_RUN),
    .reset_req (reset_req),
    .trip_next (trip_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_force_min <= 1'b1;
      reset_enable  <= 1'b0;
      cal_start     <= 1'b0;
      fault_n       <= 1'b1;
    end else begin
      out_force_min <= (state_d != ST_RUN) || trip_next;
      reset_enable  <= (state_d == ST_WAIT) || (state_d == ST_RUN);
      cal_start     <= (state_q == ST_LOCK) && (state_d == ST_CAL);
      fault_n       <= !trip_next;
    end
  end

  // R2
  brownout_chk: assert property (@(posedge clk) disable iff (rst)
    !sup_above_lo |=> (out_force_min && !reset_enable && fault_n));

  // R4
  cal_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    cal_start |=> !cal_start);

  // R9
  fault_forces_min_chk: assert property (@(posedge clk) disable iff (rst)
    !fault_n |-> out_force_min);

  // R10
  fault_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (!fault_n && reset_req && sup_above_lo) |=> fault_n);

endmodule

// File: tb/sense_supervisor_tb.sv
`timescale 1ns/1ps
module sense_supervisor_tb;

  localparam int WD = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sup_lo = 1'b0, sup_hi = 1'b0, cal_done = 1'b0, rreq = 1'b0;
  logic force_min, rst_en, cal_st, fault_n;
  int   n_chk = 0;
  int   n_fail = 0;

  always #2 clk = ~clk;

  sense_supervisor #(.WD_TIMEOUT(WD)) u_dut (
    .clk           (clk),
    .rst           (rst),
    .sup_above_lo  (sup_lo),
    .sup_above_hi  (sup_hi),
    .cal_done      (cal_done),
    .reset_req     (rreq),
    .out_force_min (force_min),
    .reset_enable  (rst_en),
    .cal_start     (cal_st),
    .fault_n       (fault_n)
  );

  // expected vector order: {force_min, reset_enable, cal_start, fault_n}
  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [3:0] exp);
    logic [3:0] act;
    act = {force_min, rst_en, cal_st, fault_n};
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic bring_up();
    sup_lo = 1; sup_hi = 1; cal_done = 0; rreq = 0; step(1);
    sup_hi = 0; step(1);
    cal_done = 1; step(1); cal_done = 0;
    rreq = 1; step(1); rreq = 0;
  endtask

  task automatic t_reset();
    rst = 1; step(2);
    check("R1", 4'b1001);
    rst = 0; step(1);
    check("R1", 4'b1001);
  endtask

  task automatic t_startup();
    sup_lo = 1; sup_hi = 0; cal_done = 1; step(5);
    check("R3", 4'b1001);          // only lower comparison: stay locked
    check("R12", 4'b1001);         // cal_done in lockout ignored
    cal_done = 0; sup_hi = 1; step(1);
    check("R4", 4'b1011);
    step(1);
    check("R4", 4'b1001);
    rreq = 1; step(3);
    check("R5", 4'b1001);          // reset request ignored during calibration
    rreq = 0; sup_hi = 0; step(2);
    check("R5", 4'b1001);
    cal_done = 1; step(1); cal_done = 0;
    check("R3", 4'b1101);          // upper drop did not relock
    check("R6", 4'b1101);
    step(3);
    check("R6", 4'b1101);
    rreq = 1; step(1);
    check("R7", 4'b0101);
    rreq = 0;
  endtask

  task automatic t_watchdog();
    rreq = 1; step(1); rreq = 0;
    step(WD - 1);
    check("R8", 4'b0101);
    step(1);
    check("R8", 4'b1100);
    step(10);
    check("R9", 4'b1100);
    rreq = 1; step(1);
    check("R10", 4'b0101);
    rreq = 0; step(WD - 1);
    check("R10", 4'b0101);
  endtask

  task automatic t_long_reset();
    rreq = 1; step(3 * WD);
    check("R11", 4'b0101);
    rreq = 0; step(WD - 1);
    check("R11", 4'b0101);
    step(1);
    check("R11", 4'b1100);
    rreq = 1; step(1); rreq = 0;
  endtask

  task automatic t_brownout();
    step(WD + 2);
    check("R9", 4'b1100);
    sup_lo = 0; sup_hi = 0; step(1);
    check("R2", 4'b1001);
    sup_lo = 1; step(3);
    check("R3", 4'b1001);
    sup_hi = 1; step(1);
    check("R12", 4'b1011);         // calibration relaunched
    sup_hi = 0; step(1);
    sup_lo = 0; step(1);           // drop during calibration
    check("R2", 4'b1001);
    sup_lo = 1; sup_hi = 1; step(1);
    check("R2", 4'b1011);          // fresh pulse proves lockout was entered
    sup_hi = 0; cal_done = 1; step(1); cal_done = 0;
    rreq = 1; step(1); rreq = 0;
    check("R7", 4'b0101);
  endtask

  initial begin
    t_reset();
    t_startup();
    t_watchdog();
    t_long_reset();
    t_brownout();
    rst = 1; step(2); rst = 0;
    bring_up();
    check("R7", 4'b0101);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog (all requirements) actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule